// File: doc/BRIEF.md
# Serial EEPROM Configuration Autoloader

After a power-on reset this block copies a self-describing block of configuration data from a 3-wire serial EEPROM into the card's local buffer SRAM. No host is involved. It reads EEPROM word 0 first. The first byte that arrives on the serial line is the count of configuration words. The block then reads exactly that many words, from EEPROM addresses 1 upward, and writes each one to SRAM as two bytes. The bytes go to consecutive addresses starting at a fixed base. The EEPROM locations above the count are never addressed.

A strap input is shared with the EEPROM chip select and is sampled once, right after reset. When the strap reads low the load runs. When it reads high the block reports completion at once and does not touch the EEPROM or the SRAM. The serial clock is the system clock divided by a parameter. The SRAM side is a plain synchronous write port that takes one byte per strobed cycle. A sticky completion flag tells the rest of the card that the configuration is in place.

Top module: `cfg_autoload`

## Requirements
- R1: The strap is sampled in the first clock cycle after reset release. If it reads high, `load_done` rises within three cycles, and `ee_cs` and `sram_we` never assert until the next reset.
- R2: Each EEPROM access sends a start/opcode sequence of 1,1,0 on `ee_di`, then the word address MSB first (ADDR_BITS bits). The EEPROM then returns a dummy zero bit, then 16 data bits MSB first. `ee_di` changes only while `ee_sk` is low. `ee_do` is sampled on the rising edge of `ee_sk`.
- R3: The first access reads address 0. The first byte shifted in (bits 15:8 of word 0) is the count N. Bits 7:0 of word 0 are ignored.
- R4: Exactly N+1 accesses are made, in the order 0, 1, ..., N. No address above N is ever read.
- R5: Data word k (1 ≤ k ≤ N) is written as its bits 7:0 at BASE_ADDR+2(k-1), then as its bits 15:8 at BASE_ADDR+2(k-1)+1. The write order is strictly ascending, one byte per `sram_we` cycle, 2N writes in all.
- R6: `load_done` rises after the last byte is written and stays high until the next reset. No `sram_we` occurs while it is high.
- R7: A count of zero ends the load after the single read of word 0, with no SRAM write.
- R8: Each `ee_sk` half period inside an access lasts exactly CLK_DIV system clocks. `ee_cs` stays low for at least 2·CLK_DIV clocks between accesses.
- R9: `ee_sk` is low whenever `ee_cs` is low.
- R10: While reset is held, `ee_cs`, `ee_sk`, `sram_we` and `load_done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_cs_n | input | 1 | Strap sampled after reset; low enables the load |
| ee_do | input | 1 | Serial data from the EEPROM |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| sram_addr | output | SRAM_AW | SRAM byte address |
| sram_wdata | output | 8 | SRAM write byte |
| sram_we | output | 1 | SRAM write strobe, one byte per cycle |
| load_done | output | 1 | Sticky completion flag |

## Verification
The bench builds the block with CLK_DIV = 2, ADDR_BITS = 8 and the default base of 0x4010. The short divider keeps a full 255-word load, which reads every data location of a 256-word device, to about thirty thousand cycles. The even divider still gives a measurable half period, so the SK timing and CS gap checks stay meaningful. With 8 address bits the bench's behavioural EEPROM can hold a count word whose low byte differs from its high byte, so taking the wrong count byte shows up.

// File: rtl/cfg_autoload_pkg.sv
package cfg_autoload_pkg;

  localparam int CNT_W = 8;
  localparam int WORD_W = 16;
  localparam logic [2:0] EE_READ_OP = 3'b110;

  typedef enum logic [2:0] {
    SQ_STRAP,
    SQ_CNT_REQ,
    SQ_CNT_WAIT,
    SQ_WORD_REQ,
    SQ_WORD_WAIT,
    SQ_LO,
    SQ_HI,
    SQ_DONE
  } seq_state_t;

  // serial clocks per access: opcode, address, dummy, data
  function automatic int unsigned serial_bits(int unsigned abits);
    return 3 + abits + 1 + WORD_W;
  endfunction

  // byte offset of data word idx (1-based), low byte first
  function automatic int unsigned byte_offset(int unsigned idx, logic hi);
    return 2 * (idx - 1) + (hi ? 1 : 0);
  endfunction

endpackage

// File: rtl/cfg_sk_divider.sv
module cfg_sk_divider #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (CLK_DIV == 1) || !tick);
endmodule

// File: rtl/cfg_ee_reader.sv
module cfg_ee_reader
  import cfg_autoload_pkg::*;
#(
  parameter int ADDR_BITS = 8,
  parameter int CLK_DIV   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_start,
  input  logic [ADDR_BITS-1:0] rd_addr,
  output logic                 rd_ready,
  output logic                 rd_vld,
  output logic [WORD_W-1:0]    rd_data,
  output logic                 ee_cs,
  output logic                 ee_sk,
  output logic                 ee_di,
  input  logic                 ee_do
);
  localparam int TOT = serial_bits(ADDR_BITS);
  localparam int BW  = $clog2(TOT + 1);
  localparam int PAD = TOT - 3 - ADDR_BITS;

  typedef enum logic [1:0] {RD_IDLE, RD_SHIFT, RD_GAP} rd_state_t;

  rd_state_t         st_q;
  logic              tick;
  logic [TOT-1:0]    cmd_q;
  logic [BW-1:0]     bits_q;
  logic              gap_q;
  logic [WORD_W-1:0] data_q;
  logic              cs_q, sk_q, vld_q;
  logic              last_fall;

  cfg_sk_divider #(.CLK_DIV(CLK_DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  assign last_fall = (st_q == RD_SHIFT) && tick && sk_q && (bits_q == BW'(TOT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RD_IDLE;
      cmd_q  <= '0;
      bits_q <= '0;
      gap_q  <= 1'b0;
      data_q <= '0;
      cs_q   <= 1'b0;
      sk_q   <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      case (st_q)
        RD_IDLE: if (rd_start) begin
          cmd_q  <= {EE_READ_OP, rd_addr, {PAD{1'b0}}};
          bits_q <= '0;
          cs_q   <= 1'b1;
          sk_q   <= 1'b0;
          st_q   <= RD_SHIFT;
        end
        RD_SHIFT: if (tick) begin
          if (!sk_q) begin
            sk_q   <= 1'b1;
            data_q <= {data_q[WORD_W-2:0], ee_do};
          end else begin
            sk_q   <= 1'b0;
            cmd_q  <= cmd_q << 1;
            bits_q <= bits_q + 1'b1;
            if (last_fall) begin
              cs_q  <= 1'b0;
              vld_q <= 1'b1;
              gap_q <= 1'b0;
              st_q  <= RD_GAP;
            end
          end
        end
        RD_GAP: if (tick) begin
          gap_q <= 1'b1;
          if (gap_q) st_q <= RD_IDLE;
        end
        default: st_q <= RD_IDLE;
      endcase
    end
  end

  assign rd_ready = (st_q == RD_IDLE);
  assign rd_vld   = vld_q;
  assign rd_data  = data_q;
  assign ee_cs    = cs_q;
  assign ee_sk    = sk_q;
  assign ee_di    = cs_q & cmd_q[TOT-1];

  assert_sk_low_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sk);
  assert_sk_moves_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ee_sk) |-> $past(tick));
  assert_di_stable_while_sk_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
  assert_start_only_when_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> !ee_cs);
endmodule

// File: rtl/cfg_autoload.sv
module cfg_autoload
  import cfg_autoload_pkg::*;
#(
  parameter int          CLK_DIV   = 4,
  parameter int          ADDR_BITS = 8,
  parameter int          SRAM_AW   = 16,
  parameter int unsigned BASE_ADDR = 32'h4010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strap_cs_n,
  input  logic               ee_do,
  output logic               ee_cs,
  output logic               ee_sk,
  output logic               ee_di,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [7:0]         sram_wdata,
  output logic               sram_we,
  output logic               load_done
);
  seq_state_t           st_q;
  logic [CNT_W-1:0]     cnt_q, idx_q;
  logic [WORD_W-1:0]    word_q;
  logic                 rd_start, rd_ready, rd_vld;
  logic [WORD_W-1:0]    rd_data;
  logic [ADDR_BITS-1:0] rd_addr;
  logic                 want_read;

  assign want_read = (st_q == SQ_CNT_REQ) || (st_q == SQ_WORD_REQ);
  assign rd_start  = want_read && rd_ready;
  assign rd_addr   = (st_q == SQ_CNT_REQ) ? '0 : ADDR_BITS'(idx_q);

  cfg_ee_reader #(.ADDR_BITS(ADDR_BITS), .CLK_DIV(CLK_DIV)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_start(rd_start),
    .rd_addr (rd_addr),
    .rd_ready(rd_ready),
    .rd_vld  (rd_vld),
    .rd_data (rd_data),
    .ee_cs   (ee_cs),
    .ee_sk   (ee_sk),
    .ee_di   (ee_di),
    .ee_do   (ee_do)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_STRAP;
      cnt_q  <= '0;
      idx_q  <= '0;
      word_q <= '0;
    end else begin
      case (st_q)
        SQ_STRAP:     st_q <= strap_cs_n ? SQ_DONE : SQ_CNT_REQ;
        SQ_CNT_REQ:   if (rd_start) st_q <= SQ_CNT_WAIT;
        SQ_CNT_WAIT:  if (rd_vld) begin
          cnt_q <= rd_data[WORD_W-1 -: CNT_W];
          idx_q <= CNT_W'(1);
          st_q  <= (rd_data[WORD_W-1 -: CNT_W] == '0) ? SQ_DONE : SQ_WORD_REQ;
        end
        SQ_WORD_REQ:  if (rd_start) st_q <= SQ_WORD_WAIT;
        SQ_WORD_WAIT: if (rd_vld) begin
          word_q <= rd_data;
          st_q   <= SQ_LO;
        end
        SQ_LO:        st_q <= SQ_HI;
        SQ_HI: begin
          if (idx_q == cnt_q) st_q <= SQ_DONE;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= SQ_WORD_REQ;
          end
        end
        SQ_DONE:      st_q <= SQ_DONE;
        default:      st_q <= SQ_DONE;
      endcase
    end
  end

  assign sram_we    = (st_q == SQ_LO) || (st_q == SQ_HI);
  assign sram_wdata = (st_q == SQ_HI) ? word_q[15:8] : word_q[7:0];
  assign sram_addr  = SRAM_AW'(BASE_ADDR + byte_offset(idx_q, st_q == SQ_HI));
  assign load_done  = (st_q == SQ_DONE);

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);
  assert_no_write_when_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> !load_done);
  assert_write_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> (32'(sram_addr) >= BASE_ADDR) &&
                (32'(sram_addr) < BASE_ADDR + 2 * 32'(cnt_q)));
  assert_bus_quiet_when_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !ee_cs);
  assert_zero_count_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && st_q == SQ_CNT_WAIT && rd_data[15:8] == 8'd0) |=> load_done);
  assert_vld_only_when_waiting_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> (st_q == SQ_CNT_WAIT) || (st_q == SQ_WORD_WAIT));
endmodule

// File: tb/cfg_autoload_test.sv
module cfg_autoload_test;
  localparam int CLK_DIV = 2;
  localparam int AB      = 8;
  localparam int BASE    = 32'h4010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_cs_n = 1'b0;
  logic ee_do = 1'b0;
  logic ee_cs, ee_sk, ee_di, sram_we, load_done;
  logic [15:0] sram_addr;
  logic [7:0]  sram_wdata;

  always #5 clk = ~clk;

  cfg_autoload #(.CLK_DIV(CLK_DIV), .ADDR_BITS(AB), .SRAM_AW(16), .BASE_ADDR(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .strap_cs_n(strap_cs_n), .ee_do(ee_do),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_we(sram_we),
    .load_done(load_done)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] mem [256];

  longint cyc = 0, fall_cyc = 0, last_sk = 0;
  bit had_fall = 0, sk_seen = 0, cs_prev = 0, sk_prev = 0;
  int in_bits = 0;
  logic [15:0] shreg = '0, cur = '0;
  int rd_n, rd_err, op_err, wr_n, wr_err, sk_err, gap_err, cs_sk_err, cs_rises, we_after_done;

  task automatic clear_counts();
    rd_n = 0; rd_err = 0; op_err = 0; wr_n = 0; wr_err = 0; sk_err = 0;
    gap_err = 0; cs_sk_err = 0; cs_rises = 0; we_after_done = 0; had_fall = 0;
  endtask

  // behavioural EEPROM and SRAM monitor, sampled away from the active edge
  always @(negedge clk) begin
    logic [15:0] w;
    logic [7:0] eb;
    cyc++;
    if (ee_cs && !cs_prev) begin
      in_bits = 0; cs_rises++; sk_seen = 0;
      if (had_fall && (cyc - fall_cyc) < 2 * CLK_DIV) gap_err++;
    end
    if (!ee_cs && cs_prev) begin had_fall = 1; fall_cyc = cyc; end
    if (!ee_cs && ee_sk) cs_sk_err++;
    if (ee_cs && ee_sk != sk_prev) begin
      if (sk_seen && (cyc - last_sk) != CLK_DIV) sk_err++;
      sk_seen = 1; last_sk = cyc;
    end
    if (ee_cs && ee_sk && !sk_prev) begin
      in_bits++;
      shreg = {shreg[14:0], ee_di};
      if (in_bits == 3 && shreg[2:0] != 3'b110) op_err++;
      if (in_bits == 3 + AB) begin
        if (int'(shreg[AB-1:0]) != rd_n) rd_err++;
        cur = mem[shreg[AB-1:0]];
        rd_n++;
      end
    end
    if (ee_cs && !ee_sk && sk_prev) begin
      if (in_bits == 3 + AB) ee_do = 1'b0;
      else if (in_bits >= 4 + AB && in_bits <= 19 + AB) ee_do = cur[15 - (in_bits - 4 - AB)];
    end
    if (sram_we) begin
      if (load_done) we_after_done++;
      w  = mem[wr_n / 2 + 1];
      eb = (wr_n % 2) ? w[15:8] : w[7:0];
      if (int'(sram_addr) != BASE + wr_n || sram_wdata != eb) begin
        if (wr_err == 0)
          $display("  write %0d: addr %h data %h, wanted addr %h data %h",
                   wr_n, sram_addr, sram_wdata, 16'(BASE + wr_n), eb);
        wr_err++;
      end
      wr_n++;
    end
    cs_prev = ee_cs;
    sk_prev = ee_sk;
  end

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fill(int n, int seed);
    for (int i = 1; i < 256; i++) mem[i] = 16'((i * 40503) ^ seed);
    mem[0] = {8'(n), 8'h07};
  endtask

  task automatic do_reset(bit strap);
    @(negedge clk);
    rst_n = 1'b0;
    strap_cs_n = strap;
    repeat (3) @(negedge clk);
    clear_counts();
    rst_n = 1'b1;
  endtask

  task automatic wait_done(int limit);
    for (int i = 0; i < limit && !load_done; i++) @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!ee_cs && !ee_sk && !sram_we && !load_done, "R10 outputs low in reset",
          {ee_cs, ee_sk, sram_we, load_done}, 0);
  endtask

  task automatic t_strap_high();
    fill(4, 32'h11);
    do_reset(1'b1);
    repeat (3) @(negedge clk);
    check(load_done, "R1 done with strap high", load_done, 1);
    repeat (200) @(negedge clk);
    check(cs_rises == 0, "R1 no EEPROM access", cs_rises, 0);
    check(wr_n == 0, "R1 no SRAM write", wr_n, 0);
  endtask

  task automatic t_load(int n, int seed);
    int rd_at_done;
    fill(n, seed);
    do_reset(1'b0);
    wait_done(40000);
    check(load_done, "R6 done reached", load_done, 1);
    check(op_err == 0, "R2 read opcode", op_err, 0);
    check(rd_err == 0, "R3 R4 address order", rd_err, 0);
    check(rd_n == n + 1, "R4 access count", rd_n, n + 1);
    check(wr_n == 2 * n, "R5 byte count", wr_n, 2 * n);
    check(wr_err == 0, "R5 byte address and data", wr_err, 0);
    check(sk_err == 0, "R8 sk half period", sk_err, 0);
    check(gap_err == 0, "R8 cs gap", gap_err, 0);
    check(cs_sk_err == 0, "R9 sk low with cs low", cs_sk_err, 0);
    rd_at_done = rd_n;
    repeat (300) @(negedge clk);
    check(load_done, "R6 done sticky", load_done, 1);
    check(we_after_done == 0 && wr_n == 2 * n, "R6 no write after done", we_after_done, 0);
    check(rd_n == rd_at_done && !ee_cs, "R4 no further access", rd_n, rd_at_done);
  endtask

  task automatic t_zero_count();
    fill(0, 32'h5a5a);
    do_reset(1'b0);
    wait_done(2000);
    check(load_done, "R7 done on zero count", load_done, 1);
    check(rd_n == 1, "R7 single read", rd_n, 1);
    check(wr_n == 0, "R7 no write", wr_n, 0);
  endtask

  initial begin
    t_reset_state();
    t_strap_high();
    t_zero_count();
    t_load(1, 32'h1234);
    t_load(5, 32'hbeef);
    t_load(17, 32'h0f0f);
    t_reset_state();
    t_load(255, 32'h7777);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule